// File: doc/BRIEF.md
# Edge-Selectable Prescaled Event Counter

This block is an 8-bit up-counter driven by qualified events. An event is either a chosen transition (rising or falling) on an external pin, or a cycle in which an internal instruction-tick enable is high. A source-select input picks which one is used. The external pin is asynchronous, so it first passes through a synchronizer, and an edge detector then turns each matching transition into a single-cycle event.

Events can pass straight to the counter. They can also go through a power-of-two prescaler whose ratio runs from 1:2 to 1:256. A small control register sets the edge polarity, whether the prescaler is used, and the divide code.

When the counter wraps from 0xFF to 0x00, the block emits a one-cycle overflow pulse and sets a sticky flag, which stays set until software clears it. A bus write can load the counter at any time. The overflow period is the event period times the prescale ratio times 256. On the internal source, one event is one instruction cycle, so a slower instruction clock scales the period in proportion.

Top module: `evt_prescale_counter`

## Requirements
- R1: After reset, `count` is 0x00, `ovf_pulse` and `ovf_flag` are 0, and the control fields are rising edge, prescaler off and divide code 000.
- R2: With control bit 4 at 0 and the pin source selected, each rising transition of `ext_pin` is one event, and a falling transition is not an event.
- R3: With control bit 4 at 1 and the pin source selected, each falling transition of `ext_pin` is one event, and a rising transition is not an event.
- R4: With control bit 3 at 0, the prescaler is bypassed and every event increments `count` by one.
- R5: With control bit 3 at 1 and divide code n in control bits 2:0, `count` increments once per 2^(n+1) events: code 000 gives 1:2 and code 111 gives 1:256.
- R6: With `src_sel` at 1, each cycle with `tick_en` high is one event, and `ext_pin` has no effect on `count`.
- R7: `count` is 8 bits wide and wraps from 0xFF to 0x00. `ovf_pulse` is high for exactly the one cycle in which `count` first shows 0x00 after the wrap.
- R8: A wrap sets `ovf_flag`, which stays set until `flag_clr` is high. If a clear and a wrap happen in the same cycle, the flag stays set.
- R9: `cnt_wr` loads `cnt_wdata` into `count` at the next edge and takes priority over an increment in the same cycle. It also restarts the prescaler count at zero.
- R10: A control write that changes the divide code restarts the prescaler count at zero.
- R11: A pin transition that is valid before a clock edge shows in `count` at the third rising edge, counting that edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_pin | input | 1 | Asynchronous external event input |
| src_sel | input | 1 | Event source: 0 selects the external pin, 1 selects the internal tick |
| tick_en | input | 1 | Internal instruction-cycle tick enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control value: bit 4 selects the falling edge, bit 3 enables the prescaler, bits 2:0 hold the divide code |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| flag_clr | input | 1 | Clear strobe for the sticky overflow flag |
| count | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on wrap |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is the prescaler's hidden remainder: its effect shows only after a multiple of the ratio in events. The bench therefore feeds a deliberately partial count of events, then issues a counter load or a divide-code change. It then feeds exactly one ratio's worth of events less one and checks that `count` has not yet moved. Only one more event may move it.

Every divide code is also swept on both pin polarities, with an event count that is not a multiple of the ratio. On the internal source, enough ticks are sent to force a wrap, and the expected count and flag come from an arithmetic model.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int CNT_W  = 8;
  localparam int DIV_W  = 3;
  localparam int SYNC_N = 2;

  typedef struct packed {
    logic             edge_fall;
    logic             pre_en;
    logic [DIV_W-1:0] div;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/epc_edge_det.sv
module epc_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  input  logic src_int,
  input  logic tick_in,
  output logic evt
);
  logic [SYNC_N-1:0] sr_q, sr_nxt;
  logic              prev_q, prev_nxt;
  logic              samp;
  logic              pin_evt;

  assign samp = sr_q[SYNC_N-1];

  always_comb begin
    sr_nxt   = {sr_q[SYNC_N-2:0], pin};
    prev_nxt = samp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sr_nxt;
      prev_q <= prev_nxt;
    end
  end

  always_comb begin
    if (fall_sel) pin_evt = prev_q & ~samp;
    else          pin_evt = samp & ~prev_q;
    evt = src_int ? tick_in : pin_evt;
  end

  // R2
  single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt && $stable(fall_sel) |=> !pin_evt);

  // R3
  edge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |-> (samp == !fall_sel));
endmodule

// File: rtl/epc_prescaler.sv
module epc_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] div,
  input  logic             clr,
  output logic             tick
);
  localparam int              PRE_W = 1 << DIV_W;
  localparam logic [PRE_W-1:0] ALL1 = '1;
  localparam logic [DIV_W-1:0] TOP  = DIV_W'(PRE_W - 1);

  logic [PRE_W-1:0] pre_q, pre_nxt, term;
  logic             hit;

  always_comb begin
    term = ALL1 >> (TOP - div);
    hit  = (pre_q == term);
  end

  always_comb begin
    pre_nxt = pre_q;
    if (clr || !pre_en)  pre_nxt = '0;
    else if (evt)        pre_nxt = hit ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end

  assign tick = pre_en ? (evt & hit) : evt;

  // R5
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |-> pre_q <= term);

  // R9
  pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre_q == '0);
endmodule

// File: rtl/epc_count8.sv
module epc_count8 #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse,
  output logic             ovf_flag
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pls_q, pls_nxt;
  logic             flg_q, flg_nxt;
  logic             wrap;

  always_comb begin
    wrap    = tick & ~ld & (cnt_q == '1);
    cnt_nxt = cnt_q;
    if (ld)        cnt_nxt = ld_val;
    else if (tick) cnt_nxt = cnt_q + CNT_W'(1);
    pls_nxt = wrap;
    flg_nxt = wrap | (flg_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      pls_q <= pls_nxt;
      flg_q <= flg_nxt;
    end
  end

  assign count     = cnt_q;
  assign ovf_pulse = pls_q;
  assign ovf_flag  = flg_q;

  // R7
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count == '0) && ovf_flag);

  // R7
  ovf_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse && !tick |=> !ovf_pulse);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);

  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(ld_val));

  // R4
  incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/evt_prescale_counter.sv
module evt_prescale_counter
  import epc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             src_sel,
  input  logic             tick_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_pulse,
  output logic             ovf_flag
);
  logic [1:0] rst_q, rst_nxt;
  logic       rst_ni;
  ctl_t       ctl_q, ctl_nxt, ctl_in;
  logic       evt, tick, pre_clr;

  assign rst_nxt = {rst_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_nxt;
  end
  assign rst_ni = rst_q[1];

  always_comb begin
    ctl_in  = ctl_t'(ctl_wdata);
    ctl_nxt = ctl_wr ? ctl_in : ctl_q;
    pre_clr = cnt_wr | (ctl_wr & (ctl_in.div != ctl_q.div));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_nxt;
  end

  epc_edge_det #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_ni), .pin(ext_pin), .fall_sel(ctl_q.edge_fall),
    .src_int(src_sel), .tick_in(tick_en), .evt(evt)
  );

  epc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_ni), .evt(evt), .pre_en(ctl_q.pre_en),
    .div(ctl_q.div), .clr(pre_clr), .tick(tick)
  );

  epc_count8 #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .ld(cnt_wr), .ld_val(cnt_wdata),
    .flag_clr(flag_clr), .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  // R6
  src_int_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    src_sel && !tick_en && !cnt_wr |=> count == $past(count));
endmodule

// File: tb/sim_evt_prescale_counter.sv
`timescale 1ns/1ps
module sim_evt_prescale_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, src_sel = 1'b0, tick_en = 1'b0;
  logic       ctl_wr = 1'b0, cnt_wr = 1'b0, flag_clr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] count;
  logic       ovf_pulse, ovf_flag;

  int total = 0, fails = 0, cyc_n = 0;
  int mcnt = 0, mpre = 0, mflag = 0, mpe = 0, mdiv = 0;

  always #4 clk = ~clk;

  evt_prescale_counter u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .src_sel(src_sel),
    .tick_en(tick_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_events(input int n);
    for (int i = 0; i < n; i++) begin
      if (mpe != 0) begin
        mpre++;
        if (mpre == (2 << mdiv)) begin
          mpre = 0;
          mcnt = (mcnt + 1) & 255;
          if (mcnt == 0) mflag = 1;
        end
      end else begin
        mcnt = (mcnt + 1) & 255;
        if (mcnt == 0) mflag = 1;
      end
    end
  endtask

  task automatic wr_ctl(input int fall, input int pe, input int dv);
    ctl_wr = 1'b1;
    ctl_wdata = {fall[0], pe[0], dv[2:0]};
    @(negedge clk);
    ctl_wr = 1'b0;
    if (dv != mdiv || pe == 0) mpre = 0;
    mpe = pe; mdiv = dv;
  endtask

  task automatic load(input int v);
    cnt_wr = 1'b1; cnt_wdata = v[7:0];
    @(negedge clk);
    cnt_wr = 1'b0;
    mcnt = v & 255; mpre = 0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    cyc(n);
    tick_en = 1'b0;
    model_events(n);
  endtask

  task automatic pulses(input int n, input bit counts);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; cyc(2);
      ext_pin = 1'b0; cyc(2);
    end
    cyc(4);
    if (counts) model_events(n);
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; mflag = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 pulse", ovf_pulse, 0);
    check("R1 flag", ovf_flag, 0);
    // R1 default control: rising edge, bypass
    pulses(3, 1'b1);
    check("R1 default rising bypass", count, 3);

    // R2 rising only
    wr_ctl(0, 0, 0);
    ext_pin = 1'b1; cyc(5);
    check("R2 rise counts", count, 4);
    ext_pin = 1'b0; cyc(5);
    check("R2 fall ignored", count, 4);
    // R3 falling only
    wr_ctl(1, 0, 0);
    ext_pin = 1'b1; cyc(5);
    check("R3 rise ignored", count, 4);
    ext_pin = 1'b0; cyc(5);
    check("R3 fall counts", count, 5);
    mcnt = 5;

    // R11 latency
    wr_ctl(0, 0, 0);
    ext_pin = 1'b1;
    @(negedge clk); check("R11 edge1", count, 5);
    @(negedge clk); check("R11 edge2", count, 5);
    @(negedge clk); check("R11 edge3", count, 6);
    ext_pin = 1'b0; cyc(4);
    mcnt = 6;

    // R4 bypass, both sources
    load(16);
    pulses(9, 1'b1);
    check("R4 ext bypass", count, mcnt);
    src_sel = 1'b1;
    ticks(37);
    cyc(1);
    check("R4 tick bypass", count, mcnt);

    // R6 pin ignored on internal source
    pulses(5, 1'b0);
    check("R6 pin ignored", count, mcnt);

    // R5 every code, both polarities, pin source
    src_sel = 1'b0;
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 8; c++) begin
        wr_ctl(f, 1, c);
        load(0);
        pulses(3 * (2 << c) + 1, 1'b1);
        check($sformatf("R5 pin code %0d edge %0d", c, f), count, mcnt);
      end
    end
    wr_ctl(0, 0, 0);

    // R5/R7/R8 every code, internal source, through a wrap
    src_sel = 1'b1;
    for (int c = 0; c < 8; c++) begin
      wr_ctl(0, 1, c);
      load(240);
      ticks(20 * (2 << c) + 3);
      cyc(1);
      check($sformatf("R5 tick code %0d", c), count, mcnt);
      check($sformatf("R8 flag code %0d", c), ovf_flag, mflag);
      clr_flag();
      check("R8 cleared", ovf_flag, 0);
    end

    // R7 pulse timing
    wr_ctl(0, 0, 0);
    load(254);
    tick_en = 1'b1;
    @(negedge clk); check("R7 at FF", count, 255);
    check("R7 no pulse at FF", ovf_pulse, 0);
    @(negedge clk); check("R7 wrapped", count, 0);
    check("R7 pulse", ovf_pulse, 1);
    tick_en = 1'b0;
    @(negedge clk); check("R7 pulse one cycle", ovf_pulse, 0);
    check("R8 flag set", ovf_flag, 1);
    cyc(3);
    check("R8 flag sticky", ovf_flag, 1);
    clr_flag();

    // R8 clear and wrap together
    load(255);
    tick_en = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; flag_clr = 1'b0;
    check("R8 set wins over clear", ovf_flag, 1);
    clr_flag();
    check("R8 clear alone", ovf_flag, 0);

    // R9 load beats tick
    load(5);
    tick_en = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'h40;
    @(negedge clk);
    tick_en = 1'b0; cnt_wr = 1'b0;
    check("R9 load priority", count, 64);

    // R9 load restarts prescaler (ratio 4)
    wr_ctl(0, 1, 1);
    load(0);
    tick_en = 1'b1; cyc(3); tick_en = 1'b0;
    load(0);
    tick_en = 1'b1; cyc(3); tick_en = 1'b0;
    check("R9 prescaler restarted", count, 0);
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    check("R9 prescaler terminal", count, 1);

    // R10 code change restarts prescaler (ratio 4 -> 8)
    load(0);
    tick_en = 1'b1; cyc(3); tick_en = 1'b0;
    wr_ctl(0, 1, 2);
    tick_en = 1'b1; cyc(7); tick_en = 1'b0;
    check("R10 restarted", count, 0);
    tick_en = 1'b1; cyc(1); tick_en = 1'b0;
    check("R10 terminal", count, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  always @(posedge clk) begin
    cyc_n <= cyc_n + 1;
    if (cyc_n == 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc_n, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule